// File: doc/BRIEF.md
# Return-Address Tamper Monitor

This block watches a processor's call and return events and the address of every data store, and flags an attempt to overwrite a saved return address. It keeps no copy of the return addresses themselves. On each call it records two word locations: the slot holding the return address (taken from the stack pointer at the call) and the slot holding the caller's frame pointer (taken from the frame pointer at the call). Any store that lands on one of these words marks the frame that owns it as tampered.

The reaction is deferred until the return. When the current frame returns, the monitor raises a halt request in that same cycle if the frame was tampered with. It also raises the request if the return target falls inside the local stack region of the returning frame. Once raised, the halt request stays high until reset.

A small stack of `DEPTH` frames (two by default) is tracked. Deeper nesting discards the oldest frame and sets a sticky overflow flag.

Top module: `ret_guard_top`

## Requirements
- R1: After reset, halt_o, tamper_o and ovf_o are 0 and no frame is tracked.
- R2: A call (call_i=1, ret_i=0) makes a new current frame. Its return-address slot is word sp_i[31:2] and its saved-frame-pointer slot is word fp_i[31:2]. The new frame starts untampered, and tamper_o is 0 in the next cycle.
- R3: A store (st_valid_i=1) whose st_addr_i[31:2] equals either slot of any tracked frame marks that frame as tampered. The low two address bits are ignored. tamper_o shows the current frame's mark from the next cycle. A store to any other word changes nothing.
- R4: A return (ret_i=1) while the current frame is marked drives halt_o to 1 combinationally in the same cycle.
- R5: A return whose target word ret_tgt_i[31:2] lies in the inclusive range from sp_i[31:2] to the current return-address slot word drives halt_o to 1 in the same cycle. A target one word below sp_i does not.
- R6: Once halt_o is 1, it stays 1 until reset.
- R7: A return discards the current frame, with its mark, and makes the caller's frame current, keeping the caller's mark. A store to the caller's slot made while the callee runs therefore halts the caller's return and not the callee's.
- R8: A call made while DEPTH frames are tracked discards the oldest frame and sets ovf_o, which stays 1 until reset.
- R9: A return with no tracked frame raises no halt and leaves all outputs unchanged.
- R10: When call_i and ret_i are both 1 in the same cycle, only the return is performed.
- R11: A store in the same cycle as a return that hits the returning frame's slots counts toward that return's halt decision.
- R12: A store in the same cycle as a call is compared against the frames that existed before the call, and never marks the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call event strobe |
| ret_i | input | 1 | Return event strobe |
| sp_i | input | 32 | Stack pointer: return-address slot on a call, lower bound of the local region on a return |
| fp_i | input | 32 | Frame pointer: saved-frame-pointer slot on a call |
| ret_tgt_i | input | 32 | Return target address, valid with ret_i |
| st_valid_i | input | 1 | Data store valid |
| st_addr_i | input | 32 | Data store byte address |
| halt_o | output | 1 | Halt request, sticky until reset |
| tamper_o | output | 1 | Current frame has been written through a guarded slot |
| ovf_o | output | 1 | Sticky: frame tracking depth was exceeded |

## Verification
The bench drives the main function with several kinds of store:
- stores to unrelated words, which show that only exact word matches count;
- stores to a byte inside a guarded word, which show that the low address bits are masked;
- stores to the return-address slot and to the frame-pointer slot separately, which tell the two comparators apart;
- stores to a caller's slot while a callee is current, which separate a mark carried with its frame from a single global flag.

Returns are tried with targets at both edges of the local region and just outside it. The remaining patterns cover empty-stack returns, overflow from a third nested call, and stores or returns in the same cycle as a call or return. A behavioural queue model predicts all three outputs in every cycle.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
    localparam int ADDR_W = 32;
    localparam int LSB_W  = 2;
    localparam int WORD_W = ADDR_W - LSB_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  live;
        word_t ra_slot;
        word_t fp_slot;
        logic  tamper;
    } frame_t;
endpackage

// File: rtl/rtm_slot_cmp.sv
module rtm_slot_cmp
    import rtm_pkg::*;
(
    input  frame_t frame_i,
    input  logic   st_valid_i,
    input  word_t  st_word_i,
    output logic   hit_o
);
    logic ra_eq;
    logic fp_eq;

    always_comb begin
        ra_eq = (st_word_i == frame_i.ra_slot);
        fp_eq = (st_word_i == frame_i.fp_slot);
        hit_o = st_valid_i & frame_i.live & (ra_eq | fp_eq);
    end
endmodule

// File: rtl/rtm_region_chk.sv
module rtm_region_chk
    import rtm_pkg::*;
(
    input  word_t ra_slot_i,
    input  word_t sp_word_i,
    input  word_t tgt_word_i,
    output logic  inside_o
);
    always_comb begin
        inside_o = (tgt_word_i >= sp_word_i) && (tgt_word_i <= ra_slot_i);
    end
endmodule

// File: rtl/rtm_frame_stack.sv
module rtm_frame_stack
    import rtm_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   call_i,
    input  logic                   ret_i,
    input  word_t                  sp_word_i,
    input  word_t                  fp_word_i,
    input  logic [DEPTH-1:0]       hit_i,
    output frame_t [DEPTH-1:0]     frames_o,
    output logic                   ovf_o
);
    typedef struct packed {
        frame_t [DEPTH-1:0] frames;
        logic               ovf;
    } stk_t;

    stk_t stk_d, stk_q;
    frame_t [DEPTH-1:0] marked;

    always_comb begin
        marked = stk_q.frames;
        for (int k = 0; k < DEPTH; k++) begin
            if (hit_i[k]) begin
                marked[k].tamper = 1'b1;
            end
        end

        stk_d        = stk_q;
        stk_d.frames = marked;

        if (ret_i) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
                stk_d.frames[k] = marked[k+1];
            end
            stk_d.frames[DEPTH-1] = '0;
        end else if (call_i) begin
            for (int k = 1; k < DEPTH; k++) begin
                stk_d.frames[k] = marked[k-1];
            end
            stk_d.frames[0] = frame_t'{live: 1'b1, ra_slot: sp_word_i,
                                       fp_slot: fp_word_i, tamper: 1'b0};
            if (marked[DEPTH-1].live) begin
                stk_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign frames_o = stk_q.frames;
    assign ovf_o    = stk_q.ovf;

    assert_call_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (call_i && !ret_i) |=> (frames_o[0].live && frames_o[0].ra_slot == $past(sp_word_i)));

    assert_call_clean_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (call_i && !ret_i) |=> !frames_o[0].tamper);

    assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> ovf_o);

    assert_ovf_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> $past(call_i));
endmodule

// File: rtl/ret_guard_top.sv
module ret_guard_top
    import rtm_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        call_i,
    input  logic        ret_i,
    input  logic [31:0] sp_i,
    input  logic [31:0] fp_i,
    input  logic [31:0] ret_tgt_i,
    input  logic        st_valid_i,
    input  logic [31:0] st_addr_i,
    output logic        halt_o,
    output logic        tamper_o,
    output logic        ovf_o
);
    typedef struct packed {
        logic halt;
    } top_t;

    top_t top_d, top_q;

    word_t sp_word, fp_word, tgt_word, st_word;
    logic  unused_lsbs;
    frame_t [DEPTH-1:0] frames;
    logic [DEPTH-1:0]   hit;
    logic               in_region;
    logic               halt_now;

    assign sp_word     = sp_i[ADDR_W-1:LSB_W];
    assign fp_word     = fp_i[ADDR_W-1:LSB_W];
    assign tgt_word    = ret_tgt_i[ADDR_W-1:LSB_W];
    assign st_word     = st_addr_i[ADDR_W-1:LSB_W];
    assign unused_lsbs = ^{sp_i[LSB_W-1:0], fp_i[LSB_W-1:0],
                           ret_tgt_i[LSB_W-1:0], st_addr_i[LSB_W-1:0]};

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            rtm_slot_cmp u_cmp (
                .frame_i    (frames[g]),
                .st_valid_i (st_valid_i),
                .st_word_i  (st_word),
                .hit_o      (hit[g])
            );
        end
    endgenerate

    rtm_region_chk u_region (
        .ra_slot_i  (frames[0].ra_slot),
        .sp_word_i  (sp_word),
        .tgt_word_i (tgt_word),
        .inside_o   (in_region)
    );

    rtm_frame_stack #(.DEPTH(DEPTH)) u_stack (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .sp_word_i (sp_word),
        .fp_word_i (fp_word),
        .hit_i     (hit),
        .frames_o  (frames),
        .ovf_o     (ovf_o)
    );

    always_comb begin
        halt_now = ret_i & frames[0].live &
                   (frames[0].tamper | hit[0] | in_region);
        top_d      = top_q;
        top_d.halt = top_q.halt | halt_now;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign halt_o   = top_q.halt | halt_now;
    assign tamper_o = frames[0].tamper;

    assert_halt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> halt_o);

    assert_halt_on_ret_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(top_q.halt) |-> $past(ret_i));

    assert_tamper_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tamper_o) |-> ($past(st_valid_i) || $past(ret_i)));

    assert_empty_ret_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_i && !frames[0].live && !top_q.halt) |-> !halt_o);
endmodule

// File: tb/test_ret_guard_top.sv
module test_ret_guard_top;
    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call = 1'b0, ret = 1'b0, stv = 1'b0;
    logic [31:0] sp = '0, fp = '0, tgt = '0, sta = '0;
    logic        halt_o, tamper_o, ovf_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic [29:0] ra;
        logic [29:0] fpw;
        bit          flag;
    } mframe_t;

    mframe_t mq[$];
    bit      halt_m = 0;
    bit      ovf_m  = 0;

    ret_guard_top #(.DEPTH(DEPTH)) i_ret_guard_top (
        .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret),
        .sp_i(sp), .fp_i(fp), .ret_tgt_i(tgt), .st_valid_i(stv),
        .st_addr_i(sta), .halt_o(halt_o), .tamper_o(tamper_o), .ovf_o(ovf_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog actual=hung expected=done");
                finish_run();
            end
        end
    end

    // One cycle: drive at negedge, compare before the posedge, advance model.
    task automatic step(input string tag, input bit c, input bit r,
                        input logic [31:0] s, input logic [31:0] f,
                        input logic [31:0] t, input bit v, input logic [31:0] a);
        bit hits[$];
        bit now;
        bit inreg;
        call = c; ret = r; sp = s; fp = f; tgt = t; stv = v; sta = a;
        #2;
        hits.delete();
        for (int i = 0; i < mq.size(); i++) begin
            hits.push_back(v && (a[31:2] == mq[i].ra || a[31:2] == mq[i].fpw));
        end
        inreg = 0;
        now   = 0;
        if (mq.size() > 0) begin
            inreg = (t[31:2] >= s[31:2]) && (t[31:2] <= mq[0].ra);
            now   = r && (mq[0].flag || hits[0] || inreg);
        end
        chk(tag, "halt_o", halt_o, halt_m || now);
        chk(tag, "tamper_o", tamper_o, (mq.size() > 0) ? mq[0].flag : 1'b0);
        chk(tag, "ovf_o", ovf_o, ovf_m);
        for (int i = 0; i < mq.size(); i++) begin
            if (hits[i]) mq[i].flag = 1;
        end
        if (r) begin
            if (mq.size() > 0) void'(mq.pop_front());
        end else if (c) begin
            mframe_t nf;
            if (mq.size() == DEPTH) begin
                void'(mq.pop_back());
                ovf_m = 1;
            end
            nf.ra = s[31:2]; nf.fpw = f[31:2]; nf.flag = 0;
            mq.push_front(nf);
        end
        halt_m = halt_m || now;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 32'h0, 32'h0, 32'h0, 0, 32'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        call = 0; ret = 0; stv = 0;
        @(negedge clk);
        @(negedge clk);
        #2;
        chk("R1", "halt_o", halt_o, 1'b0);
        chk("R1", "tamper_o", tamper_o, 1'b0);
        chk("R1", "ovf_o", ovf_o, 1'b0);
        mq.delete();
        halt_m = 0;
        ovf_m  = 0;
        rst_n  = 1'b1;
        @(negedge clk);
    endtask

    localparam logic [31:0] SP1 = 32'h0000_8F00, FP1 = 32'h0000_8F20;
    localparam logic [31:0] SP2 = 32'h0000_8E00, FP2 = 32'h0000_8E40;
    localparam logic [31:0] SP3 = 32'h0000_8D00, FP3 = 32'h0000_8D40;
    localparam logic [31:0] CODE = 32'h0000_1000;

    initial begin
        do_reset();
        idle("R1");

        // R9: return and store with nothing tracked
        step("R9", 0, 1, SP1, 0, SP1, 1, SP1);
        idle("R9");

        // R2 / R3: clean call, unrelated stores, safe return
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 0, 1, SP1 + 32'h4);
        step("R3", 0, 0, 0, 0, 0, 1, FP1 - 32'h4);
        step("R5", 0, 1, SP1 - 32'h10, 0, CODE, 0, 0);
        idle("R5");

        // R3 / R4 / R6: byte store into the return slot, halting return held
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 0, 1, SP1 + 32'h2);
        idle("R3");
        step("R4", 0, 1, SP1 - 32'h10, 0, CODE, 0, 0);
        idle("R6");
        idle("R6");

        // R3 / R4: store into the saved-frame-pointer slot
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 0, 1, FP1 + 32'h3);
        step("R4", 0, 1, SP1 - 32'h10, 0, CODE, 0, 0);
        idle("R6");

        // R5: target equals the return-slot word (upper edge)
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R5", 0, 1, SP1 - 32'h20, 0, SP1 + 32'h1, 0, 0);
        idle("R6");

        // R5: target equals sp word (lower edge)
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R5", 0, 1, SP1 - 32'h20, 0, SP1 - 32'h20, 0, 0);
        idle("R5");

        // R5: target one word below sp is outside
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R5", 0, 1, SP1 - 32'h20, 0, SP1 - 32'h24, 0, 0);
        idle("R5");

        // R7: caller slot hit while callee runs
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R2", 1, 0, SP2, FP2, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 1, SP1);
        idle("R7");
        step("R7", 0, 1, SP2 - 32'h10, 0, CODE, 0, 0);
        idle("R7");
        step("R7", 0, 1, SP1 - 32'h10, 0, CODE, 0, 0);
        idle("R6");

        // R7: callee tamper dropped on its return is not inherited
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R2", 1, 0, SP2, FP2, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 1, FP2);
        step("R7", 0, 1, SP2 - 32'h10, 0, CODE, 0, 0);
        idle("R7");

        // R8: third call drops oldest, sticky overflow, empty final return
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R2", 1, 0, SP2, FP2, 0, 0, 0);
        step("R8", 1, 0, SP3, FP3, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0, 1, SP1);
        step("R8", 0, 1, SP3 - 32'h10, 0, CODE, 0, 0);
        step("R8", 0, 1, SP2 - 32'h10, 0, CODE, 0, 0);
        step("R9", 0, 1, SP1 - 32'h10, 0, SP1, 0, 0);
        idle("R8");

        // R10: call and return together
        do_reset();
        step("R10", 1, 1, SP1, FP1, CODE, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 1, SP1);
        step("R10", 1, 0, SP1, FP1, 0, 0, 0);
        step("R10", 1, 1, SP2, FP2, CODE, 0, 0);
        step("R10", 0, 1, SP2, 0, SP2, 0, 0);
        idle("R10");

        // R11: store to the return slot in the return cycle
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R11", 0, 1, SP1 - 32'h10, 0, CODE, 1, SP1);
        idle("R11");

        // R12: store with the call hits old frame, not the new one
        do_reset();
        step("R2", 1, 0, SP1, FP1, 0, 0, 0);
        step("R12", 1, 0, SP2, FP2, 0, 1, SP2);
        step("R12", 0, 1, SP2 - 32'h10, 0, CODE, 0, 0);
        step("R12", 1, 0, SP2, FP2, 0, 1, FP1);
        step("R12", 0, 1, SP2 - 32'h10, 0, CODE, 0, 0);
        step("R12", 0, 1, SP1 - 32'h10, 0, CODE, 0, 0);
        idle("R12");

        finish_run();
    end
endmodule